// File: doc/BRIEF.md
# Timing Reference Selector

This block picks the reference that times the node. It chooses among up to three candidate references and an internal oscillator, which is always present. Each candidate comes with five inputs: a provisioning bit, a qualification bit from an upstream frequency monitor, a kind bit (line reference or external timing input), a 4-bit quality code already taken from the line, and a provisioned priority. The block compares the candidates every clock cycle. It registers the winner as the active index and raises a one-cycle strobe whenever that index moves.

Ranking uses quality first, then priority, then candidate index. A candidate is dropped if it carries the do-not-use code or if its quality is worse than the node's own clock. When no candidate survives, the internal oscillator (index 3) takes over. A maintenance input can force any eligible candidate. A second, independent ranking restricted to line references chooses the source for the outgoing external timing port. An external input therefore never loops back out.

The control is a two-state machine. In `ST_INTERNAL` the internal clock is active. `EV_ACQUIRE` moves to `ST_TRACK` as soon as any candidate is eligible. In `ST_TRACK`, `EV_RESELECT` updates the index in place when a different candidate wins. `EV_FALLBACK` returns to `ST_INTERNAL` when no candidate is left.

Top module: `tref_selector`

## Requirements
- R1: Only a candidate with its bit set in both `ref_prov` and `ref_qual` can become active.
- R2: When no candidate is eligible, `active_sel` is 3 (internal oscillator). When at least one is eligible, it is never 3.
- R3: Among eligible candidates, the lowest quality code (field i at `ref_ql[4i+3:4i]`; lower is better) is chosen.
- R4: On equal quality, the lowest priority value (field i at `ref_prio[2i+1:2i]`; lower wins) is chosen. A further tie goes to the lowest index.
- R5: A candidate whose quality code is 15 (do-not-use), or is greater than `node_ql`, is ineligible. A code equal to `node_ql` is eligible.
- R6: When the active candidate fails, `active_sel` shows the next best candidate one clock edge after the failure is presented.
- R7: `extout_valid`/`extout_sel` name the best eligible candidate whose `ref_is_line` bit is 1, ranked as in R3/R4. A candidate with `ref_is_line` = 0 is never named. `extout_valid` is 0 when no such candidate exists.
- R8: `sel_change` is 1 for exactly the cycle in which `active_sel` takes a new value, and 0 otherwise.
- R9: With `force_en` = 1, if `force_idx` names an eligible candidate (0..2), that candidate is active. Otherwise the force is ignored. The force never affects `extout_*`.
- R10: During reset, `active_sel` = 3, `sel_change` = 0, `extout_valid` = 0 and `extout_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_prov | input | 3 | Candidate provisioned, one bit per candidate |
| ref_qual | input | 3 | Candidate qualified by frequency monitor |
| ref_is_line | input | 3 | 1 = line reference, 0 = external timing input |
| ref_ql | input | 12 | Quality codes, 4 bits per candidate |
| ref_prio | input | 6 | Priorities, 2 bits per candidate |
| node_ql | input | 4 | Quality code of the internal oscillator |
| force_en | input | 1 | Maintenance forced switch enable |
| force_idx | input | 2 | Candidate to force |
| active_sel | output | 2 | Active reference index, 3 = internal |
| sel_change | output | 1 | One-cycle pulse on index change |
| extout_valid | output | 1 | Outgoing external timing port has a source |
| extout_sel | output | 2 | Candidate index feeding the outgoing port |

## Verification
A forced switch and a failure of the active reference can land in the same cycle, and they pull in different directions. The bench holds candidate 2 active, then in one cycle restores a better candidate and forces candidate 0. It expects candidate 0 after one edge, with exactly one strobe pulse. In a second case the bench forces the very candidate that is failing in that cycle. It expects the normal ranking to win, which shows the force is dropped rather than latched.

// File: rtl/tref_sel_pkg.sv
package tref_sel_pkg;
    typedef enum logic [0:0] {
        ST_INTERNAL = 1'b0,
        ST_TRACK    = 1'b1
    } sel_state_e;
endpackage

// File: rtl/tref_sel_elig.sv
module tref_sel_elig #(
    parameter int N_REF = 3,
    parameter int QW    = 4
) (
    input  logic [N_REF-1:0]    prov,
    input  logic [N_REF-1:0]    qual,
    input  logic [N_REF*QW-1:0] ql,
    input  logic [QW-1:0]       node_ql,
    output logic [N_REF-1:0]    elig
);
    // all-ones quality code is the do-not-use marker
    for (genvar g = 0; g < N_REF; g++) begin : g_cand
        logic [QW-1:0] q;
        assign q       = ql[g*QW +: QW];
        assign elig[g] = prov[g] & qual[g] & (q != {QW{1'b1}}) & (q <= node_ql);
    end
endmodule

// File: rtl/tref_sel_rank.sv
module tref_sel_rank #(
    parameter int N_REF = 3,
    parameter int QW    = 4,
    parameter int PW    = 2,
    parameter int IW    = 2
) (
    input  logic [N_REF-1:0]    mask,
    input  logic [N_REF*QW-1:0] ql,
    input  logic [N_REF*PW-1:0] prio,
    output logic                found,
    output logic [IW-1:0]       idx
);
    localparam int KW = QW + PW;

    logic [KW-1:0] best_key;
    logic [KW-1:0] cand_key;

    // quality is the major key, priority the minor; strict compare keeps lower index on ties
    always_comb begin
        found    = 1'b0;
        idx      = IW'(N_REF);
        best_key = '1;
        cand_key = '0;
        for (int i = 0; i < N_REF; i++) begin
            cand_key = {ql[i*QW +: QW], prio[i*PW +: PW]};
            if (mask[i] && (!found || cand_key < best_key)) begin
                found    = 1'b1;
                best_key = cand_key;
                idx      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tref_selector.sv
module tref_selector
    import tref_sel_pkg::*;
#(
    parameter int N_REF = 3,
    parameter int QW    = 4,
    parameter int PW    = 2,
    parameter int IW    = $clog2(N_REF + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_REF-1:0]    ref_prov,
    input  logic [N_REF-1:0]    ref_qual,
    input  logic [N_REF-1:0]    ref_is_line,
    input  logic [N_REF*QW-1:0] ref_ql,
    input  logic [N_REF*PW-1:0] ref_prio,
    input  logic [QW-1:0]       node_ql,
    input  logic                force_en,
    input  logic [IW-1:0]       force_idx,
    output logic [IW-1:0]       active_sel,
    output logic                sel_change,
    output logic                extout_valid,
    output logic [IW-1:0]       extout_sel
);
    localparam logic [IW-1:0] IDX_INTERNAL = IW'(N_REF);

    logic [N_REF-1:0] elig;
    logic             any_found;
    logic [IW-1:0]    any_idx;
    logic             line_found;
    logic [IW-1:0]    line_idx;
    logic             force_ok;
    logic [IW-1:0]    pick_idx;
    logic [IW-1:0]    next_sel;
    sel_state_e       state_q, state_d;

    tref_sel_elig #(.N_REF(N_REF), .QW(QW)) u_elig (
        .prov    (ref_prov),
        .qual    (ref_qual),
        .ql      (ref_ql),
        .node_ql (node_ql),
        .elig    (elig)
    );

    tref_sel_rank #(.N_REF(N_REF), .QW(QW), .PW(PW), .IW(IW)) u_rank_all (
        .mask  (elig),
        .ql    (ref_ql),
        .prio  (ref_prio),
        .found (any_found),
        .idx   (any_idx)
    );

    // outgoing port ranks line references only, so an external input is never relayed
    tref_sel_rank #(.N_REF(N_REF), .QW(QW), .PW(PW), .IW(IW)) u_rank_line (
        .mask  (elig & ref_is_line),
        .ql    (ref_ql),
        .prio  (ref_prio),
        .found (line_found),
        .idx   (line_idx)
    );

    always_comb begin
        force_ok = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (force_en && force_idx == IW'(i) && elig[i]) force_ok = 1'b1;
        end
        pick_idx = force_ok ? force_idx : any_idx;
    end

    // next state: EV_ACQUIRE, EV_RESELECT (stay), EV_FALLBACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INTERNAL: if (any_found)  state_d = ST_TRACK;
            ST_TRACK:    if (!any_found) state_d = ST_INTERNAL;
            default:     state_d = ST_INTERNAL;
        endcase
    end

    always_comb begin
        unique case (state_d)
            ST_TRACK:    next_sel = pick_idx;
            ST_INTERNAL: next_sel = IDX_INTERNAL;
            default:     next_sel = IDX_INTERNAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INTERNAL;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_sel   <= IDX_INTERNAL;
            sel_change   <= 1'b0;
            extout_valid <= 1'b0;
            extout_sel   <= '0;
        end else begin
            active_sel   <= next_sel;
            sel_change   <= (next_sel != active_sel);
            extout_valid <= line_found;
            extout_sel   <= line_found ? line_idx : '0;
        end
    end
endmodule

// File: rtl/tref_selector_chk.sv
module tref_selector_chk #(
    parameter int N_REF = 3,
    parameter int QW    = 4,
    parameter int PW    = 2,
    parameter int IW    = $clog2(N_REF + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_REF-1:0]    ref_prov,
    input logic [N_REF-1:0]    ref_qual,
    input logic [N_REF-1:0]    ref_is_line,
    input logic [N_REF*QW-1:0] ref_ql,
    input logic [N_REF*PW-1:0] ref_prio,
    input logic [QW-1:0]       node_ql,
    input logic                force_en,
    input logic [IW-1:0]       force_idx,
    input logic [IW-1:0]       active_sel,
    input logic                sel_change,
    input logic                extout_valid,
    input logic [IW-1:0]       extout_sel
);
    logic [N_REF-1:0]    p_prov, p_qual, p_line;
    logic [N_REF*QW-1:0] p_ql;
    logic [QW-1:0]       p_node;
    logic [IW-1:0]       p_act;
    logic                act_pq, act_qok, ext_line, any_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_prov <= '0; p_qual <= '0; p_line <= '0;
            p_ql   <= '0; p_node <= '0; p_act  <= IW'(N_REF);
        end else begin
            p_prov <= ref_prov; p_qual <= ref_qual; p_line <= ref_is_line;
            p_ql   <= ref_ql;   p_node <= node_ql;  p_act  <= active_sel;
        end
    end

    always_comb begin
        act_pq   = 1'b0;
        act_qok  = 1'b0;
        ext_line = 1'b0;
        any_prev = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (p_prov[i] && p_qual[i] && p_ql[i*QW +: QW] != {QW{1'b1}}
                && p_ql[i*QW +: QW] <= p_node) any_prev = 1'b1;
            if (active_sel == IW'(i)) begin
                act_pq  = p_prov[i] & p_qual[i];
                act_qok = (p_ql[i*QW +: QW] != {QW{1'b1}}) && (p_ql[i*QW +: QW] <= p_node);
            end
            if (extout_sel == IW'(i)) ext_line = p_line[i];
        end
    end

    a_r1_active_usable: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sel != IW'(N_REF)) |-> act_pq);
    a_r5_active_quality: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sel != IW'(N_REF)) |-> act_qok);
    a_r2_internal_iff_none: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sel == IW'(N_REF)) == !any_prev);
    a_r7_ext_from_line: assert property (@(posedge clk) disable iff (!rst_n)
        extout_valid |-> ext_line);
    a_r8_strobe_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        sel_change |-> (active_sel != p_act));
    a_r8_quiet_when_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_change |-> (active_sel == p_act));
endmodule

bind tref_selector tref_selector_chk #(.N_REF(N_REF), .QW(QW), .PW(PW), .IW(IW)) u_chk (.*);

// File: tb/tref_selector_test.sv
`timescale 1ns/1ps
module tref_selector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ref_prov = '0, ref_qual = '0, ref_is_line = '0;
    logic [11:0] ref_ql = '0;
    logic [5:0] ref_prio = '0;
    logic [3:0] node_ql = 4'd11;
    logic       force_en = 1'b0;
    logic [1:0] force_idx = '0;
    logic [1:0] active_sel;
    logic       sel_change;
    logic       extout_valid;
    logic [1:0] extout_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tref_selector uut (.*);

    typedef struct packed {
        logic [2:0]  prov, qual, line;
        logic [11:0] ql;
        logic [5:0]  prio;
        logic [3:0]  node;
        logic        fen;
        logic [1:0]  fidx;
        logic [1:0]  eact;
        logic        eev;
        logic [1:0]  ees;
    } vec_t;

    localparam int NV = 12;
    localparam logic [38:0] VECS [NV] = '{
        // R1 R2: nothing provisioned
        {3'b000,3'b000,3'b000,{4'd4,4'd4,4'd4},{2'd0,2'd0,2'd0},4'd11,1'b0,2'd0,2'd3,1'b0,2'd0},
        // R4: equal quality, priority decides; R7 line-only ranking
        {3'b111,3'b111,3'b110,{4'd4,4'd4,4'd4},{2'd3,2'd1,2'd2},4'd11,1'b0,2'd0,2'd1,1'b1,2'd1},
        // R3 R7: best quality is an external input, outgoing port stays on a line
        {3'b111,3'b111,3'b110,{4'd4,4'd4,4'd2},{2'd3,2'd1,2'd2},4'd11,1'b0,2'd0,2'd0,1'b1,2'd1},
        // R5: do-not-use code 15 rejected
        {3'b111,3'b111,3'b110,{4'd4,4'd4,4'd15},{2'd3,2'd1,2'd2},4'd11,1'b0,2'd0,2'd1,1'b1,2'd1},
        // R5 R2: all worse than node
        {3'b111,3'b111,3'b111,{4'd12,4'd12,4'd12},{2'd0,2'd0,2'd0},4'd11,1'b0,2'd0,2'd3,1'b0,2'd0},
        // R5 R4: equal to node is eligible, full tie -> lowest index
        {3'b111,3'b111,3'b111,{4'd11,4'd11,4'd11},{2'd0,2'd0,2'd0},4'd11,1'b0,2'd0,2'd0,1'b1,2'd0},
        // R1: only candidate 1 qualified
        {3'b111,3'b010,3'b111,{4'd4,4'd4,4'd4},{2'd0,2'd0,2'd0},4'd11,1'b0,2'd0,2'd1,1'b1,2'd1},
        // R9: force to worse but eligible candidate 2, port unaffected
        {3'b111,3'b111,3'b110,{4'd8,4'd4,4'd4},{2'd0,2'd0,2'd0},4'd11,1'b1,2'd2,2'd2,1'b1,2'd1},
        // R9: force to unqualified candidate ignored
        {3'b111,3'b110,3'b111,{4'd4,4'd4,4'd4},{2'd0,2'd0,2'd0},4'd11,1'b1,2'd0,2'd1,1'b1,2'd1},
        // R9 R7: force to index 3 ignored, no line candidates
        {3'b111,3'b111,3'b000,{4'd4,4'd4,4'd4},{2'd0,2'd0,2'd0},4'd11,1'b1,2'd3,2'd0,1'b0,2'd0},
        // R1 R3: unprovisioned best candidate skipped
        {3'b101,3'b111,3'b111,{4'd5,4'd2,4'd9},{2'd0,2'd0,2'd0},4'd11,1'b0,2'd0,2'd2,1'b1,2'd2},
        // R4 R7: priority picks external 2; port ties to lowest line index
        {3'b111,3'b111,3'b011,{4'd6,4'd6,4'd6},{2'd0,2'd1,2'd1},4'd11,1'b0,2'd0,2'd2,1'b1,2'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        chk("R10", "active_sel", active_sel, 3);
        chk("R10", "sel_change", sel_change, 0);
        chk("R10", "extout_valid", extout_valid, 0);
        chk("R10", "extout_sel", extout_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            ref_prov = v.prov; ref_qual = v.qual; ref_is_line = v.line;
            ref_ql = v.ql; ref_prio = v.prio; node_ql = v.node;
            force_en = v.fen; force_idx = v.fidx;
            repeat (2) @(negedge clk);
            chk("R3", $sformatf("vec %0d active_sel", i), active_sel, v.eact);
            chk("R7", $sformatf("vec %0d extout_valid", i), extout_valid, v.eev);
            if (v.eev) chk("R7", $sformatf("vec %0d extout_sel", i), extout_sel, v.ees);
        end

        // back to internal, steady
        force_en = 1'b0; ref_prov = '0;
        repeat (2) @(negedge clk);
        chk("R2", "idle active_sel", active_sel, 3);
        chk("R8", "idle sel_change", sel_change, 0);

        // R8: move 3 -> 1 pulses once, same cycle as new index
        ref_prov = 3'b111; ref_qual = 3'b111; ref_is_line = 3'b111;
        ref_ql = {4'd4, 4'd3, 4'd5}; ref_prio = '0; node_ql = 4'd11;
        @(posedge clk); #1;
        chk("R8", "acquire active_sel", active_sel, 1);
        chk("R8", "acquire sel_change", sel_change, 1);
        @(negedge clk); @(posedge clk); #1;
        chk("R8", "pulse width", sel_change, 0);
        chk("R8", "held active_sel", active_sel, 1);

        // R6: active fails -> next best one edge later
        @(negedge clk);
        ref_qual = 3'b101;
        @(posedge clk); #1;
        chk("R6", "failover active_sel", active_sel, 2);
        chk("R6", "failover sel_change", sel_change, 1);

        // same cycle: better candidate returns while force to 0 applied
        @(negedge clk);
        ref_qual = 3'b111; force_en = 1'b1; force_idx = 2'd0;
        @(posedge clk); #1;
        chk("R9", "force+restore active_sel", active_sel, 0);
        chk("R9", "force+restore sel_change", sel_change, 1);
        @(negedge clk); @(posedge clk); #1;
        chk("R8", "single pulse", sel_change, 0);

        // force target fails in the same cycle -> normal ranking
        @(negedge clk);
        ref_qual = 3'b110;
        @(posedge clk); #1;
        chk("R9", "forced target fails active_sel", active_sel, 1);
        chk("R6", "forced target fails sel_change", sel_change, 1);

        // R2: everything lost -> internal in one edge
        @(negedge clk);
        force_en = 1'b0; ref_qual = 3'b000;
        @(posedge clk); #1;
        chk("R2", "fallback active_sel", active_sel, 3);
        chk("R7", "fallback extout_valid", extout_valid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule